// File: doc/BRIEF.md
# Circulating Token Ring Channel Arbiter

This block grants exclusive use of shared channels to a set of nodes placed around a ring. Every channel owns one single-bit token that travels around the ring, moving one node per clock. A node that wants a channel raises its request with the channel number. When that channel's token reaches the node, the node takes the token off the ring. From then on the node holds the channel and its busy output stays high. When the node has finished sending, it pulses release. The token then goes back onto the ring at the next node downstream. The sender therefore sees its own token again only after a complete lap.

There is one token lane per node, holding the channel whose home is that node, plus one extra lane for a broadcast resource. A token that nobody takes keeps circulating. So, with no contention, a request waits at most one lap (`NODES` clocks). Under contention a released token reaches the waiting nodes in downstream ring order, which gives round-robin service.

Top module: `tr_token_arbiter`

## Requirements
- R1: While reset is low and after it, `busy` and `grant` are all zero. On the first clock with reset high, the token for channel c (c < `NODES`) sits at node c, and the broadcast token (channel code `NODES`) sits at node 0.
- R2: If a node has `req` high, is not busy, and the requested token is at that node before a clock edge, then after that edge `busy` is high and `grant` is high for exactly one cycle.
- R3: A token that is not taken moves from node i to node (i+1) mod `NODES` on every clock.
- R4: Each channel has at most one holder. A busy node takes no second token, whatever its request says.
- R5: A `rel` pulse from a busy node clears `busy` at the next edge and places the token at the next node downstream. The releasing node can therefore take that token back no earlier than `NODES` clocks after the release edge.
- R6: `rel` from a node that is not busy has no effect.
- R7: For every channel, the tokens on the ring plus the held copies add up to exactly one.
- R8: Channel code `NODES` selects the broadcast token. Codes above `NODES` select nothing and are never granted.
- R9: After a release, waiting requesters for that channel are served in downstream ring order from the releasing node.
- R10: A request dropped before its token arrives takes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req | input | NODES | Per-node request, level |
| req_dest | input | NODES x DW | Per-node requested channel code, DW = clog2(NODES+2) |
| rel | input | NODES | Per-node release pulse |
| grant | output | NODES | One-cycle pulse when a token is taken |
| busy | output | NODES | High while the node holds a token |

## Verification
The hardest situation to reach is a node that has released a token and keeps requesting that same channel. It must be refused while the token makes its lap, and it must still get the token the moment the lap ends. The stimulus reaches this by holding the request through the release pulse and predicting the grant exactly `NODES` clocks after the release edge. The stimulus also queues several nodes on a held channel. It then predicts each grant edge from where the released token re-enters the ring, which exercises round-robin service. That prediction also catches a token that skips a hop or stalls.

// File: rtl/tr_pkg.sv
// Package: helpers shared by the token ring arbiter.
// Assumes lanes below the node count are homed at their own index.
package tr_pkg;
    // Node at which a lane's token sits on the first clock after reset.
    function automatic int home_hop(input int lane, input int nodes);
        return (lane < nodes) ? lane : 0;
    endfunction
endpackage

// File: rtl/tr_ring.sv
// Module: tr_ring
// Holds one presence bit per (hop, lane). Each clock, every token moves
// one hop downstream unless the node at its hop takes it. Released tokens
// enter at the hop after the releasing node.
// Assumes: at most one copy of a lane exists, so take and inject never
// collide on the same lane.
module tr_ring #(
    parameter int NODES = 8,
    parameter int LANES = NODES + 1
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [NODES-1:0][LANES-1:0]  take,
    input  logic [NODES-1:0][LANES-1:0]  inject,
    output logic [NODES-1:0][LANES-1:0]  pres
);
    import tr_pkg::*;

    for (genvar h = 0; h < NODES; h++) begin : g_hop
        localparam int NX = (h + 1) % NODES;
        logic [LANES-1:0] boot;

        // Reset image for the hop that receives from hop h.
        always_comb begin
            for (int l = 0; l < LANES; l++)
                boot[l] = (home_hop(l, NODES) == NX);
        end

        // Advance untaken tokens and merge released ones.
        always_ff @(posedge clk) begin
            if (!rst_n) pres[NX] <= boot;
            else        pres[NX] <= (pres[h] & ~take[h]) | inject[h];
        end

        for (genvar l = 0; l < LANES; l++) begin : g_chk
            assert_token_advance_R3: assert property (@(posedge clk)
                disable iff (!rst_n)
                (pres[h][l] && !take[h][l]) |=> pres[NX][l]);
            assert_inject_next_hop_R5: assert property (@(posedge clk)
                disable iff (!rst_n)
                inject[h][l] |=> pres[NX][l]);
        end
    end
endmodule

// File: rtl/tr_node.sv
// Module: tr_node
// Per-node arbitration agent. It takes the requested token when it passes
// and the node is idle, holds it until release, then hands it back for
// injection downstream.
// Assumes: req_dest is stable while req waits; codes >= LANES are invalid.
module tr_node #(
    parameter int LANES = 9,
    parameter int DW    = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [LANES-1:0]  here,
    input  logic              req,
    input  logic [DW-1:0]     dest,
    input  logic              rel,
    output logic [LANES-1:0]  take,
    output logic [LANES-1:0]  inject,
    output logic [LANES-1:0]  held,
    output logic              busy,
    output logic              grant
);
    logic [LANES-1:0] held_q;
    logic             busy_q;
    logic             grant_q;

    // Decide which passing token, if any, to remove from the ring.
    always_comb begin
        for (int l = 0; l < LANES; l++)
            take[l] = req && !busy_q && (dest == DW'(l)) && here[l];
    end

    // Return the held token when a valid release arrives.
    always_comb inject = (busy_q && rel) ? held_q : '0;

    // Track ownership and the one-cycle grant pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q  <= 1'b0;
            held_q  <= '0;
            grant_q <= 1'b0;
        end else begin
            grant_q <= |take;
            if (busy_q && rel) begin
                busy_q <= 1'b0;
                held_q <= '0;
            end else if (!busy_q && |take) begin
                busy_q <= 1'b1;
                held_q <= take;
            end
        end
    end

    assign held  = held_q;
    assign busy  = busy_q;
    assign grant = grant_q;

    assert_grant_pulse_R2: assert property (@(posedge clk)
        disable iff (!rst_n) grant |=> !grant);
    assert_release_clears_R5: assert property (@(posedge clk)
        disable iff (!rst_n) (busy && rel) |=> !busy);
    assert_idle_release_R6: assert property (@(posedge clk)
        disable iff (!rst_n) (!busy && rel && !req) |=> (!busy && inject == '0));
    assert_one_token_R4: assert property (@(posedge clk)
        disable iff (!rst_n) $onehot0(held) && (busy == (held != '0)));
endmodule

// File: rtl/tr_token_arbiter.sv
// Module: tr_token_arbiter (top)
// Ring of NODES agents sharing NODES channel tokens plus one broadcast
// token. One hop per clock; a lap is NODES clocks.
// Assumes: req_dest code NODES names the broadcast lane.
module tr_token_arbiter #(
    parameter  int NODES = 8,
    localparam int LANES = NODES + 1,
    localparam int DW    = $clog2(NODES + 2)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [NODES-1:0]           req,
    input  logic [NODES-1:0][DW-1:0]   req_dest,
    input  logic [NODES-1:0]           rel,
    output logic [NODES-1:0]           grant,
    output logic [NODES-1:0]           busy
);
    logic [NODES-1:0][LANES-1:0] pres;
    logic [NODES-1:0][LANES-1:0] take;
    logic [NODES-1:0][LANES-1:0] inject;
    logic [NODES-1:0][LANES-1:0] held;

    tr_ring #(.NODES(NODES), .LANES(LANES)) ring_i (
        .clk(clk), .rst_n(rst_n), .take(take), .inject(inject), .pres(pres)
    );

    for (genvar n = 0; n < NODES; n++) begin : g_node
        tr_node #(.LANES(LANES), .DW(DW)) node_i (
            .clk(clk), .rst_n(rst_n), .here(pres[n]), .req(req[n]),
            .dest(req_dest[n]), .rel(rel[n]), .take(take[n]),
            .inject(inject[n]), .held(held[n]), .busy(busy[n]),
            .grant(grant[n])
        );
    end

    // Per-lane views across all hops and all holders, for the checks.
    logic [LANES-1:0][NODES-1:0] ring_col;
    logic [LANES-1:0][NODES-1:0] hold_col;
    always_comb begin
        for (int l = 0; l < LANES; l++)
            for (int n = 0; n < NODES; n++) begin
                ring_col[l][n] = pres[n][l];
                hold_col[l][n] = held[n][l];
            end
    end

    for (genvar l = 0; l < LANES; l++) begin : g_lane_chk
        assert_token_conserved_R7: assert property (@(posedge clk)
            disable iff (!rst_n)
            ($countones(ring_col[l]) + $countones(hold_col[l])) == 1);
        assert_single_holder_R4: assert property (@(posedge clk)
            disable iff (!rst_n) $onehot0(hold_col[l]));
    end
endmodule

// File: tb/tr_token_arbiter_tb.sv
`timescale 1ns/1ps
// Scoreboard bench: the stimulus pushes predicted grant edges, and a
// monitor pops them as grant pulses appear.
module tr_token_arbiter_tb_top;
    localparam int NODES = 8;
    localparam int DW    = $clog2(NODES + 2);

    logic                     clk = 1'b0;
    logic                     rst_n;
    logic [NODES-1:0]         req;
    logic [NODES-1:0][DW-1:0] req_dest;
    logic [NODES-1:0]         rel;
    logic [NODES-1:0]         grant;
    logic [NODES-1:0]         busy;

    int checks = 0;
    int errors = 0;
    int cyc    = 0;
    bit done   = 1'b0;

    typedef struct { int node; int edge_no; string tag; } exp_t;
    exp_t q[$];

    tr_token_arbiter #(.NODES(NODES)) dut_i (
        .clk(clk), .rst_n(rst_n), .req(req), .req_dest(req_dest),
        .rel(rel), .grant(grant), .busy(busy)
    );

    always #2 clk = ~clk;

    // Edge counter: edge 1 is the first clock with reset high.
    always @(posedge clk) begin
        if (!rst_n) cyc <= 0;
        else        cyc <= cyc + 1;
    end

    task automatic check(input bit ok, input string tag, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d (edge %0d)", tag, act, expv, cyc);
        end
    endtask

    task automatic expect_grant(input int node, input int edge_no, input string tag);
        exp_t e;
        e.node = node; e.edge_no = edge_no; e.tag = tag;
        q.push_back(e);
    endtask

    task automatic step_to(input int e);
        while (cyc < e) @(negedge clk);
    endtask

    // Monitor: compare each grant pulse with the head of the queue.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            for (int n = 0; n < NODES; n++) begin
                if (grant[n]) begin
                    if (q.size() == 0) begin
                        check(1'b0, "R4/R10 unexpected grant node", n, -1);
                    end else begin
                        exp_t e;
                        e = q.pop_front();
                        check(e.node == n, {e.tag, " grant node"}, n, e.node);
                        check(e.edge_no == cyc, {e.tag, " grant edge"}, cyc, e.edge_no);
                    end
                end
            end
        end
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 60);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; req = '0; req_dest = '0; rel = '0;
        repeat (3) @(negedge clk);
        check(busy == '0, "R1 busy in reset", busy, 0);
        check(grant == '0, "R1 grant in reset", grant, 0);
        rst_n = 1'b1;

        // R1/R3: lane 0 starts at node 0, so it reaches node 3 at edge 4.
        req[3] = 1'b1; req_dest[3] = 4'd0;
        expect_grant(3, 4, "R1/R3");
        // R8: broadcast code 8 starts at node 0 and reaches node 7 at edge 8.
        req[7] = 1'b1; req_dest[7] = 4'd8;
        expect_grant(7, 8, "R8");
        // R8: invalid code, which must never be granted.
        req[2] = 1'b1; req_dest[2] = 4'd12;

        @(negedge clk);
        check(busy == '0, "R1 busy after reset", busy, 0);
        rel[5] = 1'b1;                       // R6: idle release
        @(negedge clk);
        rel[5] = 1'b0;
        check(busy[5] == 1'b0, "R6 idle release", busy[5], 0);

        step_to(4);
        check(busy[3] == 1'b1, "R2 busy after take", busy[3], 1);
        req[3] = 1'b0;
        step_to(5);
        check(grant[3] == 1'b0, "R2 grant single cycle", grant[3], 0);
        check(busy[3] == 1'b1, "R2 hold persists", busy[3], 1);

        step_to(8);
        check(busy[7] == 1'b1, "R8 broadcast held", busy[7], 1);
        req_dest[7] = 4'd2;                  // R4: busy node asks again
        req[1] = 1'b1; req_dest[1] = 4'd0;
        req[6] = 1'b1; req_dest[6] = 4'd0;

        step_to(10);
        check(busy[1] == 1'b0, "R4 held lane not shared n1", busy[1], 0);
        check(busy[6] == 1'b0, "R4 held lane not shared n6", busy[6], 0);
        rel[3] = 1'b1;                       // release edge 11, token at node 4
        expect_grant(6, 14, "R9");
        @(negedge clk);
        rel[3] = 1'b0;
        check(busy[3] == 1'b0, "R5 release clears busy", busy[3], 0);

        step_to(14);
        check(busy[6] == 1'b1, "R9 downstream first", busy[6], 1);
        check(busy[1] == 1'b0, "R9 upstream waits", busy[1], 0);
        req[6] = 1'b0;
        step_to(16);
        rel[6] = 1'b1;                       // release edge 17, token at node 7
        expect_grant(1, 20, "R9");
        @(negedge clk);
        rel[6] = 1'b0;

        step_to(20);
        check(busy[1] == 1'b1, "R9 next in ring order", busy[1], 1);
        step_to(22);
        rel[1] = 1'b1;                       // release edge 23, req stays high
        expect_grant(1, 31, "R5 self lap");
        @(negedge clk);
        rel[1] = 1'b0;
        check(busy[1] == 1'b0, "R5 released", busy[1], 0);
        step_to(25);
        check(busy[1] == 1'b0, "R5 self retake blocked", busy[1], 0);
        step_to(31);
        check(busy[1] == 1'b1, "R5 retake after lap", busy[1], 1);
        req[1] = 1'b0;

        // R10: lane 5 is at node 5 before edge 33 and would reach node 0 at 36.
        step_to(32);
        req[0] = 1'b1; req_dest[0] = 4'd5;
        step_to(34);
        req[0] = 1'b0;
        step_to(38);
        check(busy[0] == 1'b0, "R10 dropped request", busy[0], 0);
        step_to(40);
        req[0] = 1'b1;                       // R6/R3: lane 5 still on schedule
        expect_grant(0, 44, "R3/R6");
        step_to(44);
        check(busy[0] == 1'b1, "R3 lane 5 granted", busy[0], 1);

        step_to(50);
        check(busy[2] == 1'b0, "R8 invalid code", busy[2], 0);
        check(busy[7] == 1'b1, "R4 busy node keeps one token", busy[7], 1);
        check(q.size() == 0, "R2 all predicted grants seen", q.size(), 0);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule